// File: doc/BRIEF.md
# Synchronous Serial Character Transmitter (SPI Master)

This block is the transmit side of a serial port running as a synchronous SPI master. Software writes a character of 5 to 9 bits into a holding register. The block moves the character into a shift register and sends it most significant bit first on a data output. No start, parity or stop bits are added. The serial clock comes from the system clock through a programmable divider. Clock polarity and phase are programmable, and an active-low chip select frames each character.

Chip select is pulsed once for each character by default. Two control commands let software hold chip select low across several characters and then let it go. The mode register is guarded by a write-protect register that only a key value unlocks. Two status outputs tell software when the holding register can take a new character and when the transmitter has drained.

Top module: `spi_char_tx`

## Requirements
- R1: A character is sent most significant bit first, with no start, parity or stop bit; the bits captured at the sampling edges equal the written data (data register, address 3, bits [8:0]) masked to the character length.
- R2: The mode register (address 0) holds a length field in bits [1:0] that selects 5 + field bits per character (5, 6, 7 or 8).
- R3: Mode bit [2], when set, selects 9-bit characters whatever the length field holds.
- R4: Mode bit [3] sets the clock polarity (idle level of the serial clock). Mode bit [4] sets the phase. With phase 0, data is sampled on the edge leaving the idle level. With phase 1, it is sampled on the edge returning to it.
- R5: The divider register (address 1) sets the bit period in system clocks. Each period has a first half of ceil(D/2) clocks and a second half of max(1, floor(D/2)) clocks, so a divider of 1 runs as 2.
- R6: While the divider is 0 the serial clock is stopped. A written character is not started, and it goes out once a nonzero divider is written.
- R7: Without forcing, chip select falls one short half before the first bit slot and rises one long half after the last bit slot. This gives a lead of hB (phase 1) or hB+hA (phase 0) before the first clock edge, and a trail of hA (phase 0) or hB+hA (phase 1) after the last edge, where hA = ceil(D/2) and hB = max(1, floor(D/2)).
- R8: Between characters that are not forced, chip select stays high for at least one full bit period.
- R9: Control register (address 2) bit [0] forces chip select low at once and across characters. Bit [1] releases it and wins when both are set.
- R10: The write-protect register (address 4) takes bits [31:8] = 0x5C7A19 as key, and bit [0] of a keyed write sets the lock (1 = locked). The block comes out of reset locked. While locked, or after a write with a wrong key, mode writes are ignored.
- R11: The ready output is high when the holding register is empty. It falls in the clock after a data write and rises again when the shifter takes the character.
- R12: The empty output is high only when both the holding register and the shifter are empty. It is never high while ready is low.
- R13: After reset, and whenever no character is in flight, the serial clock rests at the polarity level, the data output is low and chip select is high (unless forced).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 mode, 1 divider, 2 control, 3 data, 4 write protect) |
| wr_data | input | 32 | Register write data |
| tx_ready | output | 1 | Holding register empty |
| tx_empty | output | 1 | Holding register and shifter both empty |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Active-low chip select |

## Verification
The bench builds the block with its default 16-bit divider width but drives only dividers 0 to 5. Frames therefore stay a few dozen clocks long, and every combination of character length (including the 9-bit override with each length field), polarity, phase and divider 1 to 5 can be swept. That sweep covers the clamped divider of 1 and the uneven halves of odd dividers, where lead, trail and bit period are predicted by arithmetic. Separate runs cover the stopped divider, back-to-back characters, forced chip select and the write-protect key.

// File: rtl/sct_pkg.sv
// Shared constants, types and helpers for the serial character transmitter.
// Assumes the register map fixed in the brief.
package sct_pkg;

    localparam logic [2:0]  ADDR_MODE  = 3'd0;
    localparam logic [2:0]  ADDR_DIV   = 3'd1;
    localparam logic [2:0]  ADDR_CTRL  = 3'd2;
    localparam logic [2:0]  ADDR_DATA  = 3'd3;
    localparam logic [2:0]  ADDR_GUARD = 3'd4;
    localparam logic [23:0] GUARD_KEY  = 24'h5C7A19;
    localparam int          CHAR_MAX   = 9;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL,
        ST_GAP
    } sct_state_e;

    typedef enum logic [1:0] {
        SLOT_SHORT,
        SLOT_LONG,
        SLOT_FULL
    } sct_slot_e;

    // Packed so that a mode write maps wr_data[4:0] straight onto it.
    typedef struct packed {
        logic       cpha;
        logic       cpol;
        logic       nine;
        logic [1:0] len;
    } sct_mode_t;

    // Number of data bits in a character for a given mode.
    function automatic logic [3:0] char_bits(sct_mode_t m);
        return m.nine ? 4'd9 : (4'd5 + {2'b00, m.len});
    endfunction

endpackage

// File: rtl/sct_regs.sv
// Register file: mode (write protected), divider, chip-select force control,
// key-guarded lock and the transmit holding register.
// Assumes DIV_W <= 32 and one register write per clock.
module sct_regs
    import sct_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [2:0]           wr_addr,
    input  logic [31:0]          wr_data,
    input  logic                 take,
    output sct_mode_t            mode,
    output logic [DIV_W-1:0]     divider,
    output logic [CHAR_MAX-1:0]  hold_data,
    output logic                 hold_full,
    output logic                 force_cs,
    output logic                 locked
);

    logic wr_mode, wr_div, wr_ctrl, wr_data_q, wr_guard;

    // Decode the write strobe per register.
    always_comb begin
        wr_mode   = wr_en && (wr_addr == ADDR_MODE);
        wr_div    = wr_en && (wr_addr == ADDR_DIV);
        wr_ctrl   = wr_en && (wr_addr == ADDR_CTRL);
        wr_data_q = wr_en && (wr_addr == ADDR_DATA);
        wr_guard  = wr_en && (wr_addr == ADDR_GUARD) && (wr_data[31:8] == GUARD_KEY);
    end

    // Lock flag: only a keyed write changes it.
    always_ff @(posedge clk) begin
        if (!rst_n)        locked <= 1'b1;
        else if (wr_guard) locked <= wr_data[0];
    end

    // Mode register, writable only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode <= '0;
        else if (wr_mode && !locked) mode <= sct_mode_t'(wr_data[4:0]);
    end

    // Baud divider register.
    always_ff @(posedge clk) begin
        if (!rst_n)      divider <= '0;
        else if (wr_div) divider <= wr_data[DIV_W-1:0];
    end

    // Chip-select force flag; release wins over force.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_cs <= 1'b0;
        end else if (wr_ctrl) begin
            if (wr_data[1])      force_cs <= 1'b0;
            else if (wr_data[0]) force_cs <= 1'b1;
        end
    end

    // Holding register full flag; a write wins over a take in the same clock.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_full <= 1'b0;
        else if (wr_data_q) hold_full <= 1'b1;
        else if (take)      hold_full <= 1'b0;
    end

    // Holding register data.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_data <= '0;
        else if (wr_data_q) hold_data <= wr_data[CHAR_MAX-1:0];
    end

endmodule

// File: rtl/sct_baud.sv
// Half-period slot timer. Loads a slot length (short half, long half or a
// full bit period) and flags the last clock of the slot. Freezes while the
// divider is zero. Assumes load is only raised with a nonzero divider.
module sct_baud
    import sct_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] divider,
    input  logic             load,
    input  sct_slot_e        sel,
    output logic             slot_end
);

    localparam int CW = DIV_W + 1;

    logic [CW-1:0] half_long, half_short, slot_len, cnt;

    // Split the bit period into a long and a short half, short at least 1.
    always_comb begin
        half_long  = ({1'b0, divider} + CW'(1)) >> 1;
        half_short = {1'b0, divider} >> 1;
        if (half_short == '0) half_short = CW'(1);
    end

    // Pick the length of the slot being loaded.
    always_comb begin
        case (sel)
            SLOT_LONG: slot_len = half_long;
            SLOT_FULL: slot_len = half_long + half_short;
            default:   slot_len = half_short;
        endcase
    end

    // Count the current slot down.
    always_ff @(posedge clk) begin
        if (!rst_n)                             cnt <= '0;
        else if (load)                          cnt <= slot_len;
        else if (cnt != '0 && divider != '0)    cnt <= cnt - CW'(1);
    end

    assign slot_end = (cnt == CW'(1)) && (divider != '0);

endmodule

// File: rtl/sct_shifter.sv
// Character sequencer and shift register. Walks lead, 2N clock slots, trail
// and gap, and drives the serial clock, data and framing chip select.
// Assumes slot_end pulses once at the last clock of each loaded slot.
module sct_shifter
    import sct_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  sct_mode_t           mode,
    input  logic                div_nz,
    input  logic [CHAR_MAX-1:0] hold_data,
    input  logic                hold_full,
    input  logic                force_cs,
    input  logic                slot_end,
    output logic                take,
    output logic                load,
    output sct_slot_e           sel,
    output sct_state_e          state,
    output logic [3:0]          nbits,
    output logic                sck,
    output logic                mosi,
    output logic                cs_n
);

    logic [4:0]          slot;
    logic [CHAR_MAX-1:0] sh;
    logic                last_slot;
    logic [3:0]          bits_new;

    // Start condition, character length and end-of-character detect.
    always_comb begin
        take      = (state == ST_IDLE) && hold_full && div_nz;
        bits_new  = char_bits(mode);
        last_slot = (slot == ({nbits, 1'b0} - 5'd1));
    end

    // Slot timer load requests: which half comes next.
    always_comb begin
        load = 1'b0;
        sel  = SLOT_SHORT;
        case (state)
            ST_IDLE:  if (take)     begin load = 1'b1; sel = SLOT_SHORT; end
            ST_LEAD:  if (slot_end) begin load = 1'b1; sel = SLOT_LONG;  end
            ST_SHIFT: if (slot_end) begin load = 1'b1; sel = slot[0] ? SLOT_LONG : SLOT_SHORT; end
            ST_TRAIL: if (slot_end) begin load = 1'b1; sel = SLOT_FULL;  end
            default:  ;
        endcase
    end

    // Sequencer state, slot index and shift register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            slot  <= '0;
            nbits <= 4'd5;
            sh    <= '0;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    state <= ST_LEAD;
                    slot  <= '0;
                    nbits <= bits_new;
                    sh    <= hold_data << (4'd9 - bits_new);
                end
                ST_LEAD: if (slot_end) begin
                    state <= ST_SHIFT;
                    slot  <= '0;
                end
                ST_SHIFT: if (slot_end) begin
                    if (last_slot) state <= ST_TRAIL;
                    else           slot  <= slot + 5'd1;
                    if (slot[0])   sh    <= sh << 1;
                end
                ST_TRAIL: if (slot_end) state <= ST_GAP;
                ST_GAP:   if (slot_end) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    // Pin levels from the sequencer state.
    always_comb begin
        sck  = mode.cpol ^ ((state == ST_SHIFT) && (slot[0] ^ mode.cpha));
        mosi = 1'b0;
        if (state == ST_SHIFT)                     mosi = sh[CHAR_MAX-1];
        else if (state == ST_LEAD && !mode.cpha)   mosi = sh[CHAR_MAX-1];
        cs_n = !(force_cs || state == ST_LEAD || state == ST_SHIFT || state == ST_TRAIL);
    end

endmodule

// File: rtl/spi_char_tx.sv
// Top of the SPI master character transmitter: register file, slot timer
// and sequencer. Assumes a single clock domain and DIV_W <= 32.
module spi_char_tx
    import sct_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [2:0]  wr_addr,
    input  logic [31:0] wr_data,
    output logic        tx_ready,
    output logic        tx_empty,
    output logic        sck,
    output logic        mosi,
    output logic        cs_n
);

    sct_mode_t           mode;
    logic [DIV_W-1:0]    divider;
    logic [CHAR_MAX-1:0] hold_data;
    logic                hold_full, force_cs, locked;
    logic                take, load, slot_end, div_nz;
    sct_slot_e           sel;
    sct_state_e          st;
    logic [3:0]          nbits;

    assign div_nz = (divider != '0);

    sct_regs #(.DIV_W(DIV_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .take(take), .mode(mode), .divider(divider),
        .hold_data(hold_data), .hold_full(hold_full), .force_cs(force_cs),
        .locked(locked)
    );

    sct_baud #(.DIV_W(DIV_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .divider(divider), .load(load),
        .sel(sel), .slot_end(slot_end)
    );

    sct_shifter u_shift (
        .clk(clk), .rst_n(rst_n), .mode(mode), .div_nz(div_nz),
        .hold_data(hold_data), .hold_full(hold_full), .force_cs(force_cs),
        .slot_end(slot_end), .take(take), .load(load), .sel(sel),
        .state(st), .nbits(nbits), .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    // Status flags.
    always_comb begin
        tx_ready = !hold_full;
        tx_empty = !hold_full && (st == ST_IDLE);
    end

endmodule

// File: rtl/sct_checker.sv
// Property checker for spi_char_tx, attached through bind.
module sct_checker
    import sct_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [2:0]       wr_addr,
    input logic             tx_ready,
    input logic             tx_empty,
    input logic             sck,
    input logic             mosi,
    input logic             cs_n,
    input sct_state_e       state,
    input sct_mode_t        mode,
    input logic [DIV_W-1:0] divider,
    input logic             force_cs,
    input logic             locked,
    input logic [3:0]       nbits
);

    AST_WRITE_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n) (wr_en && wr_addr == ADDR_DATA) |=> !tx_ready); // R11
    AST_EMPTY_NEEDS_READY:  assert property (@(posedge clk) disable iff (!rst_n) tx_empty |-> tx_ready); // R12
    AST_IDLE_LEVELS:        assert property (@(posedge clk) disable iff (!rst_n) (state == ST_IDLE || state == ST_GAP) |-> (sck == mode.cpol && !mosi)); // R13
    AST_HALT_ON_ZERO:       assert property (@(posedge clk) disable iff (!rst_n) (divider == '0) |=> $stable(state)); // R6
    AST_FORCE_HOLDS_CS:     assert property (@(posedge clk) disable iff (!rst_n) force_cs |-> !cs_n); // R9
    AST_LOCKED_MODE:        assert property (@(posedge clk) disable iff (!rst_n) (locked && wr_en && wr_addr == ADDR_MODE) |=> $stable(mode)); // R10
    AST_GAP_CS_HIGH:        assert property (@(posedge clk) disable iff (!rst_n) (state == ST_GAP && !force_cs) |-> cs_n); // R8
    AST_LEN_RANGE:          assert property (@(posedge clk) disable iff (!rst_n) (state == ST_SHIFT) |-> (nbits >= 4'd5 && nbits <= 4'd9)); // R2

endmodule

bind spi_char_tx sct_checker #(.DIV_W(DIV_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .tx_ready(tx_ready), .tx_empty(tx_empty), .sck(sck), .mosi(mosi),
    .cs_n(cs_n), .state(st), .mode(mode), .divider(divider),
    .force_cs(force_cs), .locked(locked), .nbits(nbits)
);

// File: tb/spi_char_tx_tb.sv
`timescale 1ns/1ps
module spi_char_tx_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        tx_ready, tx_empty, sck, mosi, cs_n;

    int checks = 0;
    int errors = 0;

    spi_char_tx u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .tx_ready(tx_ready), .tx_empty(tx_empty),
        .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    always #4 clk = ~clk;

    // Line monitor state.
    bit     cpol_b = 0, cpha_b = 0;
    logic   prev_cs = 1'b1, prev_sck = 1'b0;
    int     cyc = 0, frames = 0, bits = 0, per_exp = 2, per_bad = 0;
    int     t_fall = 0, t_rise = -1, first_edge = -1, last_edge = 0, last_samp = -1;
    int     lead_c = 0, trail_c = 0, gap_c = 0;
    longint val = 0;

    // Decode the pins at the falling clock edge.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (prev_cs && !cs_n) begin
                t_fall = cyc; bits = 0; val = 0; first_edge = -1;
                last_samp = -1; per_bad = 0;
                if (t_rise >= 0) gap_c = cyc - t_rise;
            end
            if (!cs_n && sck != prev_sck) begin
                if (first_edge < 0) first_edge = cyc;
                last_edge = cyc;
                if (cpha_b ? (prev_sck != cpol_b) : (prev_sck == cpol_b)) begin
                    val = (val << 1) | longint'(mosi);
                    bits++;
                    if (last_samp >= 0 && (cyc - last_samp) != per_exp) per_bad++;
                    last_samp = cyc;
                end
            end
            if (!prev_cs && cs_n) begin
                lead_c  = first_edge - t_fall;
                trail_c = cyc - last_edge;
                t_rise  = cyc;
                frames++;
            end
        end
        prev_cs  = cs_n;
        prev_sck = sck;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input int len, input bit nine, input bit pol, input bit pha);
        wr(3'd0, {27'd0, pha, pol, nine, 2'(len)});
        cpol_b = pol; cpha_b = pha;
    endtask

    task automatic wait_empty();
        do @(negedge clk); while (!tx_empty);
    endtask

    task automatic wait_frames(input int target);
        while (frames < target) @(negedge clk);
    endtask

    function automatic int half_a(input int d); return (d + 1) / 2; endfunction
    function automatic int half_b(input int d); return (d / 2 == 0) ? 1 : d / 2; endfunction

    // Send one character and check value, length, timing and idle levels.
    task automatic send_check(input int data, input int n, input int d, input bit nine);
        int f0, ha, hb, exp_val;
        ha = half_a(d); hb = half_b(d);
        per_exp = ha + hb;
        f0 = frames;
        exp_val = data & ((1 << n) - 1);
        wr(3'd3, 32'(data));
        wait_frames(f0 + 1);
        chk(tx_ready && !tx_empty, "R12", "empty low while gap runs", {tx_ready, tx_empty}, 2'b10);
        chk(val == longint'(exp_val), "R1 R4", "received value", val, exp_val);
        chk(bits == n, nine ? "R3" : "R2", "bit count", bits, n);
        chk(per_bad == 0, "R5", "bit period mismatches", per_bad, 0);
        chk(lead_c == (cpha_b ? hb : hb + ha), "R7", "cs lead", lead_c, cpha_b ? hb : hb + ha);
        chk(trail_c == (cpha_b ? hb + ha : ha), "R7", "cs trail", trail_c, cpha_b ? hb + ha : ha);
        wait_empty();
        chk(sck == cpol_b && !mosi && cs_n, "R13", "idle levels", {sck, mosi, cs_n}, {cpol_b, 2'b01});
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready && tx_empty, "R11 R12", "reset status", {tx_ready, tx_empty}, 2'b11);
        chk(cs_n && !sck && !mosi, "R13", "reset pins", {cs_n, sck, mosi}, 3'b100);

        // R10: locked after reset, wrong key keeps it locked, right key opens it.
        wr(3'd0, 32'h0000_0008);
        @(negedge clk);
        chk(sck == 1'b0, "R10", "mode write while locked", sck, 0);
        wr(3'd4, {24'h5C7A18, 8'h00});
        wr(3'd0, 32'h0000_0008);
        @(negedge clk);
        chk(sck == 1'b0, "R10", "mode write after wrong key", sck, 0);
        wr(3'd4, {24'h5C7A19, 8'h00});
        wr(3'd0, 32'h0000_0008);
        @(negedge clk);
        chk(sck == 1'b1, "R10", "mode write after unlock", sck, 1);

        // R6: zero divider holds a written character back.
        set_mode(3, 0, 0, 0);
        wr(3'd3, 32'h0B3);
        repeat (40) @(negedge clk);
        chk(!tx_ready && !tx_empty && cs_n, "R6 R11", "stalled with zero divider",
            {tx_ready, tx_empty, cs_n}, 3'b001);
        per_exp = 4;
        wr(3'd1, 32'd4);
        wait_frames(1);
        chk(val == 64'hB3 && bits == 8, "R6", "character after divider set", val, 64'hB3);
        wait_empty();

        // R1 to R5, R7, R13: sweep divider, polarity/phase and lengths.
        for (int d = 1; d <= 5; d++) begin
            wr(3'd1, 32'(d));
            for (int pm = 0; pm < 4; pm++) begin
                for (int f = 0; f < 5; f++) begin
                    int data;
                    data = (d * 37 + pm * 11 + f * 53 + 'h1A5) & 'h1FF;
                    if (f == 4) set_mode(d % 4, 1, pm[0], pm[1]);
                    else        set_mode(f, 0, pm[0], pm[1]);
                    send_check(data, (f == 4) ? 9 : 5 + f, d, f == 4);
                end
            end
        end

        // R8: back-to-back characters keep a bit period of chip select high.
        set_mode(3, 0, 0, 0);
        wr(3'd1, 32'd3);
        per_exp = 3;
        begin
            int f0;
            f0 = frames;
            wr(3'd3, 32'h0C5);
            while (!tx_ready) @(negedge clk);
            wr(3'd3, 32'h03A);
            wait_frames(f0 + 2);
            chk(gap_c >= 3, "R8", "cs high gap", gap_c, 3);
            chk(val == 64'h3A, "R8", "second character", val, 64'h3A);
            wait_empty();
        end

        // R9: forced chip select spans two characters until release.
        begin
            int f0;
            f0 = frames;
            wr(3'd2, 32'h1);
            chk(!cs_n, "R9", "force takes effect", cs_n, 0);
            wr(3'd3, 32'h0A5);
            while (!tx_ready) @(negedge clk);
            wr(3'd3, 32'h05C);
            wait_empty();
            repeat (4) @(negedge clk);
            chk(!cs_n && frames == f0, "R9", "cs held across characters", cs_n, 0);
            wr(3'd2, 32'h2);
            @(negedge clk);
            chk(cs_n && frames == f0 + 1, "R9", "release ends frame", cs_n, 1);
            chk(bits == 16 && val == 64'hA55C, "R9", "two characters in one frame", val, 64'hA55C);
            wr(3'd2, 32'h1);
            wr(3'd2, 32'h3);
            @(negedge clk);
            chk(cs_n, "R9", "release wins over force", cs_n, 1);
        end

        finish_run();
    end

endmodule